// File: doc/BRIEF.md
# Hashed bucket lookup table

This block keeps host address records, such as next-hop entries keyed by a 32-bit IPv4 address, in a hash-indexed set-associative store. Each key is folded by a CRC-style hash into a bucket number, and each bucket offers a fixed number of slots. A new key takes the lowest free slot of its bucket. When the bucket has no free slot, the request is turned away and a saturating collision total is bumped. Entries are never evicted to make room.

Entries carry a class bit. Entries of the host class are held to a table-wide quota that is supplied as an input. A second hash with a different polynomial can be switched on at run time. It then acts as a fallback bucket for inserts and as a second search place for lookups and deletes. Lookup, insert and delete requests arrive over a valid/ready handshake. Only one request is in flight at a time, and every request gets a response exactly two cycles after it is accepted.

Top module: `hbt_table`

## Requirements
- R1: The primary bucket is a CRC of the key with zero start value, key bits taken from bit 31 down to bit 0: on each bit, feedback = msb of the remainder XOR key bit, the remainder shifts left by one, and it is XORed with the polynomial when feedback is 1. The primary polynomial is 0x03 and the alternate polynomial is 0x27 (both 6-bit at default). An accepted insert reports its bucket on `rsp_bucket`.
- R2: An insert of an absent key goes into the lowest-numbered free slot of its primary bucket and returns status 0 (ok), with the bucket and slot it used.
- R3: With dual hashing off, an insert of an absent key whose primary bucket is full returns status 2 (collision) and stores nothing, so a later lookup of that key misses.
- R4: `coll_count` rises by one on every collision status, holds at its all-ones maximum, and reads zero the cycle after `clr_coll` is high. Clear wins over an increment in the same cycle.
- R5: With `dual_en` high, a full primary bucket sends the insert to the lowest free slot of the alternate bucket, which returns status 0. If both buckets are full, the status is 2 (collision).
- R6: A lookup compares the key with every valid slot of the primary bucket, and also of the alternate bucket when `dual_en` is high. A hit returns `rsp_hit`=1 with the stored data, bucket and slot. A miss returns `rsp_hit`=0.
- R7: A request is accepted when `req_valid` and `req_ready` are both high. `rsp_valid` is high for exactly one cycle, two clock edges after acceptance, and `req_ready` is low for the cycle in between.
- R8: An insert of a key that is already present replaces its data in place and returns status 1 (updated) with `rsp_hit`=1. This happens even when the host quota is reached, and it uses no slot.
- R9: An insert of an absent host-class key (`req_host`=1) while `host_count` >= `host_quota` returns status 3 (quota) and stores nothing, and the collision total does not move. Non-host inserts ignore the quota.
- R10: A delete of a present key frees its slot and returns `rsp_hit`=1. If the entry was host-class, it lowers `host_count`. A delete of an absent key returns `rsp_hit`=0 and changes nothing.
- R11: Reset empties the table and zeroes both counters. It leaves `rsp_valid` at 0 and `req_ready` at 1.
- R12: `host_count` equals the number of resident host-class entries and changes by at most one per cycle.

Operation codes on `req_op`: 0 lookup, 1 insert, 2 delete, 3 treated as lookup. `rsp_data` is the stored data on a lookup hit and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dual_en | input | 1 | Enables the alternate bucket for all operations |
| host_quota | input | HC_W | Ceiling on resident host-class entries |
| clr_coll | input | 1 | Zeroes the collision total |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 2 | 0 lookup, 1 insert, 2 delete |
| req_key | input | KEY_W | Address key |
| req_data | input | DATA_W | Record data for insert |
| req_host | input | 1 | Class bit of the inserted entry |
| rsp_valid | output | 1 | Response strobe |
| rsp_status | output | 2 | 0 ok, 1 updated, 2 collision, 3 quota |
| rsp_hit | output | 1 | Key was resident before the operation |
| rsp_data | output | DATA_W | Stored data on a lookup hit |
| rsp_bucket | output | BKT_W | Bucket of the hit or of the new entry |
| rsp_slot | output | log2(SLOTS) | Slot of the hit or of the new entry |
| coll_count | output | COLL_W | Saturating collision total |
| host_count | output | HC_W | Resident host-class entries |

## Verification
The bench searches for keys that share one primary bucket, fills that bucket, and then pushes one more key in. A design that overwrote a slot or wrapped its slot search would report ok here instead of a collision. The same key is then retried with the fallback enabled, first with the fallback bucket empty and then with it full. This catches a design that never falls back, or that falls back into an occupied bucket. The collision total is driven past its maximum, so a wrapping counter shows zero. Quota cases cover an update made at the quota (it must still succeed), a non-host insert at the quota, and a host insert after a host delete, which shows whether the occupancy count was lowered.

// File: rtl/hbt_pkg.sv
package hbt_pkg;
   typedef enum logic [1:0] {
      OP_LOOKUP = 2'd0,
      OP_INSERT = 2'd1,
      OP_DELETE = 2'd2
   } hbt_op_e;

   typedef enum logic [1:0] {
      ST_OK        = 2'd0,
      ST_UPDATED   = 2'd1,
      ST_COLLISION = 2'd2,
      ST_QUOTA     = 2'd3
   } hbt_status_e;
endpackage

// File: rtl/hbt_hash.sv
// Bit-serial CRC fold of a key down to an index, unrolled into logic.
module hbt_hash #(
   parameter int KEY_W = 32,
   parameter int OUT_W = 6,
   parameter logic [OUT_W-1:0] POLY = 'h03
) (
   input  logic [KEY_W-1:0] key,
   output logic [OUT_W-1:0] idx
);
   always_comb begin
      logic [OUT_W-1:0] rem;
      logic             fb;
      rem = '0;
      for (int i = KEY_W - 1; i >= 0; i--) begin
         fb  = rem[OUT_W-1] ^ key[i];
         rem = {rem[OUT_W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end
      idx = rem;
   end
endmodule

// File: rtl/hbt_bucket_scan.sv
// Parallel compare of one bucket row: match position and lowest free slot.
module hbt_bucket_scan #(
   parameter int SLOTS = 8,
   parameter int KEY_W = 32,
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic [SLOTS-1:0]            vld,
   input  logic [SLOTS-1:0][KEY_W-1:0] keys,
   input  logic [KEY_W-1:0]            key,
   output logic                        hit,
   output logic [SLOT_W-1:0]           hit_slot,
   output logic                        has_free,
   output logic [SLOT_W-1:0]           free_slot
);
   logic [SLOTS-1:0] eq;

   for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
      assign eq[s] = vld[s] && (keys[s] == key);
   end

   always_comb begin
      hit       = |eq;
      has_free  = ~&vld;
      hit_slot  = '0;
      free_slot = '0;
      for (int s = SLOTS - 1; s >= 0; s--) begin
         if (eq[s])   hit_slot  = SLOT_W'(s);
         if (!vld[s]) free_slot = SLOT_W'(s);
      end
   end
endmodule

// File: rtl/hbt_sat_count.sv
// Saturating up-counter; clear dominates.
module hbt_sat_count #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (clr)               cnt <= '0;
      else if (inc && cnt != '1)  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/hbt_table.sv
module hbt_table
   import hbt_pkg::*;
#(
   parameter int BKT_W  = 6,
   parameter int SLOTS  = 8,
   parameter int KEY_W  = 32,
   parameter int DATA_W = 16,
   parameter int COLL_W = 16,
   parameter bit DUAL_SUPPORT = 1'b1,
   parameter logic [BKT_W-1:0] POLY_PRI = 'h03,
   parameter logic [BKT_W-1:0] POLY_ALT = 'h27,
   localparam int NUM_BKT = 1 << BKT_W,
   localparam int SLOT_W  = $clog2(SLOTS),
   localparam int HC_W    = $clog2(NUM_BKT * SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dual_en,
   input  logic [HC_W-1:0]   host_quota,
   input  logic              clr_coll,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [KEY_W-1:0]  req_key,
   input  logic [DATA_W-1:0] req_data,
   input  logic              req_host,
   output logic              rsp_valid,
   output logic [1:0]        rsp_status,
   output logic              rsp_hit,
   output logic [DATA_W-1:0] rsp_data,
   output logic [BKT_W-1:0]  rsp_bucket,
   output logic [SLOT_W-1:0] rsp_slot,
   output logic [COLL_W-1:0] coll_count,
   output logic [HC_W-1:0]   host_count
);
   // ---------------- elaboration checks ----------------
   if (BKT_W < 2 || BKT_W > 12) begin : g_bad_bkt
      $error("hbt_table: BKT_W must lie in 2..12");
   end
   if (SLOTS < 2) begin : g_bad_slots
      $error("hbt_table: SLOTS must be at least 2");
   end
   if (NUM_BKT * SLOTS > 4096) begin : g_bad_size
      $error("hbt_table: table larger than 4096 entries");
   end
   if (KEY_W < BKT_W || DATA_W < 1 || COLL_W < 1) begin : g_bad_width
      $error("hbt_table: bad key, data or counter width");
   end
   if (!POLY_PRI[0] || !POLY_ALT[0]) begin : g_bad_poly
      $error("hbt_table: hash polynomials need a constant term");
   end
   if (DUAL_SUPPORT && POLY_PRI == POLY_ALT) begin : g_same_poly
      $error("hbt_table: alternate polynomial must differ");
   end

   // ---------------- storage ----------------
   logic [SLOTS-1:0]              vld_q [NUM_BKT];
   logic [SLOTS-1:0]              cls_q [NUM_BKT];
   logic [SLOTS-1:0][KEY_W-1:0]   key_q [NUM_BKT];
   logic [SLOTS-1:0][DATA_W-1:0]  dat_q [NUM_BKT];

   // ---------------- request stage ----------------
   logic              s1_vld;
   logic [1:0]        s1_op;
   logic [KEY_W-1:0]  s1_key;
   logic [DATA_W-1:0] s1_data;
   logic              s1_host;
   logic              s1_dual;
   logic [BKT_W-1:0]  s1_bp;
   logic [BKT_W-1:0]  s1_ba;

   logic [BKT_W-1:0]  h_pri;
   logic [BKT_W-1:0]  h_alt;
   logic              dual_cfg;
   logic              accept;

   assign req_ready = !s1_vld;
   assign accept    = req_valid && !s1_vld;

   hbt_hash #(.KEY_W(KEY_W), .OUT_W(BKT_W), .POLY(POLY_PRI)) u_hash_pri (
      .key (req_key),
      .idx (h_pri)
   );

   if (DUAL_SUPPORT) begin : g_dual
      hbt_hash #(.KEY_W(KEY_W), .OUT_W(BKT_W), .POLY(POLY_ALT)) u_hash_alt (
         .key (req_key),
         .idx (h_alt)
      );
      assign dual_cfg = dual_en;
   end else begin : g_single
      assign h_alt    = '0;
      assign dual_cfg = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld  <= 1'b0;
         s1_op   <= '0;
         s1_key  <= '0;
         s1_data <= '0;
         s1_host <= 1'b0;
         s1_dual <= 1'b0;
         s1_bp   <= '0;
         s1_ba   <= '0;
      end else begin
         s1_vld <= accept;
         if (accept) begin
            s1_op   <= req_op;
            s1_key  <= req_key;
            s1_data <= req_data;
            s1_host <= req_host;
            s1_dual <= dual_cfg;
            s1_bp   <= h_pri;
            s1_ba   <= h_alt;
         end
      end
   end

   // ---------------- bucket scans ----------------
   logic              p_hit, p_free, a_hit, a_free;
   logic [SLOT_W-1:0] p_hslot, p_fslot, a_hslot, a_fslot;

   hbt_bucket_scan #(.SLOTS(SLOTS), .KEY_W(KEY_W)) u_scan_pri (
      .vld       (vld_q[s1_bp]),
      .keys      (key_q[s1_bp]),
      .key       (s1_key),
      .hit       (p_hit),
      .hit_slot  (p_hslot),
      .has_free  (p_free),
      .free_slot (p_fslot)
   );

   hbt_bucket_scan #(.SLOTS(SLOTS), .KEY_W(KEY_W)) u_scan_alt (
      .vld       (vld_q[s1_ba]),
      .keys      (key_q[s1_ba]),
      .key       (s1_key),
      .hit       (a_hit),
      .hit_slot  (a_hslot),
      .has_free  (a_free),
      .free_slot (a_fslot)
   );

   // ---------------- decision ----------------
   logic              match;
   logic [BKT_W-1:0]  m_bkt;
   logic [SLOT_W-1:0] m_slot;
   logic              new_ent, dat_we, del_en, coll_inc, hc_inc, hc_dec;
   logic [BKT_W-1:0]  wr_bkt;
   logic [SLOT_W-1:0] wr_slot;
   hbt_status_e       st;
   logic              r_hit;
   logic [DATA_W-1:0] r_data;

   assign match  = p_hit || (s1_dual && a_hit);
   assign m_bkt  = p_hit ? s1_bp   : s1_ba;
   assign m_slot = p_hit ? p_hslot : a_hslot;

   always_comb begin
      new_ent  = 1'b0;
      dat_we   = 1'b0;
      del_en   = 1'b0;
      coll_inc = 1'b0;
      hc_inc   = 1'b0;
      hc_dec   = 1'b0;
      wr_bkt   = m_bkt;
      wr_slot  = m_slot;
      st       = ST_OK;
      r_hit    = 1'b0;
      r_data   = '0;
      if (s1_vld) begin
         case (s1_op)
            OP_INSERT: begin
               if (match) begin
                  dat_we = 1'b1;
                  st     = ST_UPDATED;
                  r_hit  = 1'b1;
               end else if (s1_host && host_count >= host_quota) begin
                  st = ST_QUOTA;
               end else if (p_free) begin
                  new_ent = 1'b1;
                  dat_we  = 1'b1;
                  hc_inc  = s1_host;
                  wr_bkt  = s1_bp;
                  wr_slot = p_fslot;
               end else if (s1_dual && a_free) begin
                  new_ent = 1'b1;
                  dat_we  = 1'b1;
                  hc_inc  = s1_host;
                  wr_bkt  = s1_ba;
                  wr_slot = a_fslot;
               end else begin
                  st       = ST_COLLISION;
                  coll_inc = 1'b1;
                  wr_bkt   = '0;
                  wr_slot  = '0;
               end
            end
            OP_DELETE: begin
               if (match) begin
                  del_en = 1'b1;
                  hc_dec = cls_q[m_bkt][m_slot];
                  r_hit  = 1'b1;
               end else begin
                  wr_bkt  = '0;
                  wr_slot = '0;
               end
            end
            default: begin
               if (match) begin
                  r_hit  = 1'b1;
                  r_data = dat_q[m_bkt][m_slot];
               end else begin
                  wr_bkt  = '0;
                  wr_slot = '0;
               end
            end
         endcase
      end
   end

   // ---------------- table update ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < NUM_BKT; b++) begin
            vld_q[b] <= '0;
            cls_q[b] <= '0;
         end
      end else if (new_ent) begin
         vld_q[wr_bkt][wr_slot] <= 1'b1;
         cls_q[wr_bkt][wr_slot] <= s1_host;
      end else if (del_en) begin
         vld_q[m_bkt][m_slot] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (new_ent) key_q[wr_bkt][wr_slot] <= s1_key;
      if (dat_we)  dat_q[wr_bkt][wr_slot] <= s1_data;
   end

   // ---------------- counters ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      host_count <= '0;
      else if (hc_inc) host_count <= host_count + 1'b1;
      else if (hc_dec) host_count <= host_count - 1'b1;
   end

   hbt_sat_count #(.W(COLL_W)) u_coll (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_coll),
      .inc   (coll_inc),
      .cnt   (coll_count)
   );

   // ---------------- response ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_status <= '0;
         rsp_hit    <= 1'b0;
         rsp_data   <= '0;
         rsp_bucket <= '0;
         rsp_slot   <= '0;
      end else begin
         rsp_valid <= s1_vld;
         if (s1_vld) begin
            rsp_status <= st;
            rsp_hit    <= r_hit;
            rsp_data   <= r_data;
            rsp_bucket <= wr_bkt;
            rsp_slot   <= wr_slot;
         end
      end
   end
endmodule

// File: rtl/hbt_table_chk.sv
module hbt_table_chk #(
   parameter int COLL_W = 16,
   parameter int HC_W   = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr_coll,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [1:0]        rsp_status,
   input logic [COLL_W-1:0] coll_count,
   input logic [HC_W-1:0]   host_count
);
   localparam logic [COLL_W-1:0] CMAX = '1;
   localparam logic [1:0] S_COLL  = 2'd2;
   localparam logic [1:0] S_QUOTA = 2'd3;

   AST_RSP_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !rsp_valid ##1 rsp_valid); // R7
   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready); // R7
   AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R7
   AST_COLL_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_status == S_COLL && !$past(clr_coll) && $past(coll_count) != CMAX
      |-> coll_count == $past(coll_count) + 1'b1); // R3
   AST_COLL_HOLD_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      coll_count == CMAX && !clr_coll |=> coll_count == CMAX); // R4
   AST_COLL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clr_coll |=> coll_count == '0); // R4
   AST_QUOTA_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_status == S_QUOTA |-> host_count == $past(host_count)); // R9
   AST_HOST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      host_count == $past(host_count) || host_count == $past(host_count) + 1'b1
      || host_count == $past(host_count) - 1'b1); // R12
endmodule

bind hbt_table hbt_table_chk #(.COLL_W(COLL_W), .HC_W(HC_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clr_coll   (clr_coll),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .rsp_status (rsp_status),
   .coll_count (coll_count),
   .host_count (host_count)
);

// File: tb/tb_hbt_table.sv
module tb_hbt_table;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dual_en = 1'b0;
   logic [9:0]  host_quota = 10'd3;
   logic        clr_coll = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_op = 2'd0;
   logic [31:0] req_key = '0;
   logic [15:0] req_data = '0;
   logic        req_host = 1'b0;
   logic        rsp_valid;
   logic [1:0]  rsp_status;
   logic        rsp_hit;
   logic [15:0] rsp_data;
   logic [5:0]  rsp_bucket;
   logic [2:0]  rsp_slot;
   logic [3:0]  coll_count;
   logic [9:0]  host_count;

   int nchk = 0;
   int nfail = 0;
   int lat_err = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   hbt_table #(.COLL_W(4)) dut (
      .clk(clk), .rst_n(rst_n), .dual_en(dual_en), .host_quota(host_quota),
      .clr_coll(clr_coll), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_key(req_key), .req_data(req_data), .req_host(req_host),
      .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_hit(rsp_hit),
      .rsp_data(rsp_data), .rsp_bucket(rsp_bucket), .rsp_slot(rsp_slot),
      .coll_count(coll_count), .host_count(host_count)
   );

   function automatic logic [5:0] crc6(input logic [31:0] k, input logic [5:0] p);
      logic [5:0] r = '0;
      for (int i = 31; i >= 0; i--) begin
         logic fb = r[5] ^ k[i];
         r = {r[4:0], 1'b0};
         if (fb) r = r ^ p;
      end
      return r;
   endfunction

   function automatic logic [5:0] hp(input logic [31:0] k);
      return crc6(k, 6'h03);
   endfunction
   function automatic logic [5:0] ha(input logic [31:0] k);
      return crc6(k, 6'h27);
   endfunction

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic do_op(input logic [1:0] op, input logic [31:0] key, input logic [15:0] d,
                        input logic h, output logic [1:0] st, output logic hit,
                        output logic [15:0] rd, output logic [5:0] bk, output logic [2:0] sl);
      @(negedge clk);
      if (!req_ready) lat_err++;
      req_valid = 1'b1; req_op = op; req_key = key; req_data = d; req_host = h;
      @(negedge clk);
      req_valid = 1'b0;
      if (rsp_valid || req_ready) lat_err++;
      @(negedge clk);
      if (!rsp_valid) lat_err++;
      st = rsp_status; hit = rsp_hit; rd = rsp_data; bk = rsp_bucket; sl = rsp_slot;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   typedef struct packed {
      logic [1:0]  op;
      logic [31:0] key;
      logic [15:0] d;
      logic        h;
      logic [1:0]  st;
      logic        hit;
      logic [15:0] rd;
   } vec_t;

   // op: 0 lookup, 1 insert, 2 delete; status 0 ok, 1 updated, 3 quota (quota = 3)
   localparam vec_t VEC [16] = '{
      '{2'd1, 32'h0A000001, 16'h0011, 1'b0, 2'd0, 1'b0, 16'h0000},
      '{2'd0, 32'h0A000001, 16'h0000, 1'b0, 2'd0, 1'b1, 16'h0011},
      '{2'd1, 32'h0A000001, 16'h0022, 1'b0, 2'd1, 1'b1, 16'h0000},
      '{2'd0, 32'h0A000001, 16'h0000, 1'b0, 2'd0, 1'b1, 16'h0022},
      '{2'd0, 32'h0A000002, 16'h0000, 1'b0, 2'd0, 1'b0, 16'h0000},
      '{2'd1, 32'h0A000002, 16'h0033, 1'b1, 2'd0, 1'b0, 16'h0000},
      '{2'd1, 32'h0A000003, 16'h0044, 1'b1, 2'd0, 1'b0, 16'h0000},
      '{2'd1, 32'h0A000004, 16'h0055, 1'b1, 2'd0, 1'b0, 16'h0000},
      '{2'd1, 32'h0A000005, 16'h0066, 1'b1, 2'd3, 1'b0, 16'h0000},
      '{2'd1, 32'h0A000004, 16'h0077, 1'b1, 2'd1, 1'b1, 16'h0000},
      '{2'd0, 32'h0A000004, 16'h0000, 1'b0, 2'd0, 1'b1, 16'h0077},
      '{2'd0, 32'h0A000005, 16'h0000, 1'b0, 2'd0, 1'b0, 16'h0000},
      '{2'd2, 32'h0A000002, 16'h0000, 1'b0, 2'd0, 1'b1, 16'h0000},
      '{2'd1, 32'h0A000005, 16'h0088, 1'b1, 2'd0, 1'b0, 16'h0000},
      '{2'd2, 32'h0A000009, 16'h0000, 1'b0, 2'd0, 1'b0, 16'h0000},
      '{2'd1, 32'h0A000006, 16'h0099, 1'b0, 2'd0, 1'b0, 16'h0000}
   };

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL R7 watchdog: actual hung expected completion");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   initial begin : main
      logic [1:0]  st;
      logic        hit;
      logic [15:0] rd;
      logic [5:0]  bk;
      logic [2:0]  sl;
      logic [31:0] fk [8];
      logic [31:0] xk;
      logic [31:0] cand;
      logic [5:0]  bkt_b, bkt_a2;
      int          n;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R11: reset state
      chk("R11 ready after reset", 32'(req_ready), 32'd1);
      chk("R11 rsp_valid after reset", 32'(rsp_valid), 32'd0);
      chk("R11 coll_count after reset", 32'(coll_count), 32'd0);
      chk("R11 host_count after reset", 32'(host_count), 32'd0);

      // vector walk (R2 R6 R8 R9 R10)
      foreach (VEC[i]) begin
         do_op(VEC[i].op, VEC[i].key, VEC[i].d, VEC[i].h, st, hit, rd, bk, sl);
         chk($sformatf("R2/R8/R9 vector %0d status", i), 32'(st), 32'(VEC[i].st));
         chk($sformatf("R6/R10 vector %0d hit", i), 32'(hit), 32'(VEC[i].hit));
         chk($sformatf("R6 vector %0d data", i), 32'(rd), 32'(VEC[i].rd));
         if (VEC[i].op == 2'd1 && VEC[i].st == 2'd0)
            chk($sformatf("R1 vector %0d bucket", i), 32'(bk), 32'(hp(VEC[i].key)));
      end
      chk("R12 host_count after walk", 32'(host_count), 32'd3);
      chk("R9 no collisions counted", 32'(coll_count), 32'd0);

      // R11: reset clears the table
      do_reset();
      chk("R11 host_count cleared", 32'(host_count), 32'd0);
      do_op(2'd0, 32'h0A000001, 16'h0, 1'b0, st, hit, rd, bk, sl);
      chk("R11 table emptied", 32'(hit), 32'd0);

      // find 8 keys sharing primary bucket, and a 9th with a different alternate
      bkt_b = hp(32'hC0A80001);
      n = 0;
      cand = 32'hC0A80000;
      while (n < 8) begin
         if (hp(cand) == bkt_b) begin fk[n] = cand; n++; end
         cand++;
      end
      while (!(hp(cand) == bkt_b && ha(cand) != bkt_b)) cand++;
      xk = cand;
      bkt_a2 = ha(xk);

      for (int j = 0; j < 8; j++) begin
         do_op(2'd1, fk[j], 16'(16'h0100 + j), 1'b0, st, hit, rd, bk, sl);
         chk("R2 fill status", 32'(st), 32'd0);
         chk("R2 fill slot lowest free", 32'(sl), 32'(j));
         chk("R1 fill bucket", 32'(bk), 32'(bkt_b));
      end
      do_op(2'd1, xk, 16'h0BAD, 1'b0, st, hit, rd, bk, sl);
      chk("R3 full bucket collision", 32'(st), 32'd2);
      chk("R4 count after one collision", 32'(coll_count), 32'd1);
      do_op(2'd0, xk, 16'h0, 1'b0, st, hit, rd, bk, sl);
      chk("R3 rejected key absent", 32'(hit), 32'd0);
      do_op(2'd0, fk[7], 16'h0, 1'b0, st, hit, rd, bk, sl);
      chk("R3 last resident intact", 32'(rd), 32'h0107);

      // dual hashing
      dual_en = 1'b1;
      do_op(2'd1, xk, 16'h0ABC, 1'b0, st, hit, rd, bk, sl);
      chk("R5 fallback insert status", 32'(st), 32'd0);
      chk("R5 fallback bucket", 32'(bk), 32'(bkt_a2));
      chk("R4 no count on fallback", 32'(coll_count), 32'd1);
      do_op(2'd0, xk, 16'h0, 1'b0, st, hit, rd, bk, sl);
      chk("R6 dual lookup hit", 32'(hit), 32'd1);
      chk("R6 dual lookup data", 32'(rd), 32'h0ABC);
      chk("R6 dual lookup bucket", 32'(bk), 32'(bkt_a2));
      dual_en = 1'b0;
      do_op(2'd0, xk, 16'h0, 1'b0, st, hit, rd, bk, sl);
      chk("R6 single-hash lookup misses alternate", 32'(hit), 32'd0);

      // delete from alternate, then fill alternate bucket
      dual_en = 1'b1;
      do_op(2'd2, xk, 16'h0, 1'b0, st, hit, rd, bk, sl);
      chk("R10 delete in alternate", 32'(hit), 32'd1);
      dual_en = 1'b0;
      n = 0;
      cand = 32'h0B000000;
      while (n < 8) begin
         if (hp(cand) == bkt_a2) begin
            do_op(2'd1, cand, 16'h0200, 1'b0, st, hit, rd, bk, sl);
            chk("R2 alternate bucket fill", 32'(st), 32'd0);
            n++;
         end
         cand++;
      end
      dual_en = 1'b1;
      do_op(2'd1, xk, 16'h0CDE, 1'b0, st, hit, rd, bk, sl);
      chk("R5 both buckets full collision", 32'(st), 32'd2);
      chk("R4 count after second collision", 32'(coll_count), 32'd2);
      dual_en = 1'b0;

      // saturation
      for (int j = 0; j < 14; j++) do_op(2'd1, xk, 16'h0, 1'b0, st, hit, rd, bk, sl);
      chk("R4 counter saturates", 32'(coll_count), 32'd15);
      @(negedge clk); clr_coll = 1'b1;
      @(negedge clk); clr_coll = 1'b0;
      chk("R4 counter cleared", 32'(coll_count), 32'd0);
      do_op(2'd1, xk, 16'h0, 1'b0, st, hit, rd, bk, sl);
      chk("R4 counts after clear", 32'(coll_count), 32'd1);

      // latency, directed
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'd0; req_key = fk[0];
      @(negedge clk);
      req_valid = 1'b0;
      chk("R7 no response after one edge", 32'(rsp_valid), 32'd0);
      chk("R7 busy while in flight", 32'(req_ready), 32'd0);
      @(negedge clk);
      chk("R7 response after two edges", 32'(rsp_valid), 32'd1);
      chk("R6 location slot", 32'(rsp_slot), 32'd0);
      chk("R6 location bucket", 32'(rsp_bucket), 32'(bkt_b));
      @(negedge clk);
      chk("R7 response one cycle wide", 32'(rsp_valid), 32'd0);
      chk("R7 ready again", 32'(req_ready), 32'd1);
      chk("R7 handshake timing over all ops", 32'(lat_err), 32'd0);
      chk("R12 no host entries in fill phase", 32'(host_count), 32'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule